// File: doc/BRIEF.md
# Serial Flash Fast-Read Target

This block is the device side of a serial NOR flash that answers two read commands: a fast read that returns data on one line and a fast read that returns data on two lines. It oversamples the select, serial clock and input data pins with the system clock. It collects an opcode, a 24-bit address and a dummy phase, then streams bytes from a synchronous byte-wide memory onto one or two output lines. Each output line has its own tri-state enable.

Reads continue at consecutive addresses for as long as select stays low. The memory is read one byte ahead of the shifter, so a byte boundary never stalls the output. Opcodes other than the two read commands park the block until select is released. The serial clock half-period must be at least four system clocks.

Top module: `sfr_target`

## Requirements
- R1: Opcode 0x0B starts a one-line read and opcode 0x3B starts a two-line read. Any other opcode leaves both output enables low until select is released, whatever follows on the serial clock.
- R2: Each bit is sampled on a rising serial clock edge. A command frame is 8 opcode bits, then 24 address bits sent most significant bit first, then 8 dummy clocks.
- R3: Read data changes only after falling serial clock edges. The first data slice is driven after the falling edge that follows the 40th rising edge.
- R4: In one-line mode, dq1 carries each byte most significant bit first over 8 clocks, and dq0 is never driven.
- R5: In two-line mode, each clock carries two bits. dq1 carries bits 7, 5, 3, 1 and dq0 carries bits 6, 4, 2, 0, so a byte takes 4 clocks. dq0 is driven only in this mode.
- R6: The read address starts anywhere and advances by one after every byte. Only the low clog2(MEM_BYTES) address bits are used, and the address wraps from the top of the array to zero.
- R7: Reset or a high select clears the frame state and drives both output enables low within four system clocks. The next selection starts a fresh command.
- R8: Memory reads are single-cycle pulses on mem_en_o with mem_addr_o, and the data is taken on mem_rdata_i one clock later. A read of N whole bytes issues exactly N+2 requests: one at the address, one at the start of data, and one at each byte boundary.
- R9: Both output enables stay low during the opcode, address and dummy phases.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, oversamples the serial pins |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sel_ni | input | 1 | Active-low device select |
| ser_clk_i | input | 1 | Serial clock, idles low |
| dq0_i | input | 1 | Serial data line 0, input side |
| dq0_o | output | 1 | Serial data line 0, output value (two-line mode) |
| dq0_oe_o | output | 1 | Drive enable for line 0 |
| dq1_o | output | 1 | Serial data line 1, output value |
| dq1_oe_o | output | 1 | Drive enable for line 1 |
| mem_en_o | output | 1 | Memory read request pulse |
| mem_addr_o | output | clog2(MEM_BYTES) | Memory read address |
| mem_rdata_i | input | 8 | Memory read data, one clock after the request |

## Verification
Several properties are checked on every cycle. The output enables fall after a deselect. Line 0 is driven only in two-line mode. Line 1 changes only after a detected falling edge in the data phase. Memory requests are never back to back. An enable rises only while a stream is active, and the ignore state holds while select is low.

Only the bench scenarios can show the rest, against a behavioural model: exact bit order on both lines, address increment and wrap with high address bits discarded, the request count per read, that unknown opcodes produce no output, and that a new command is decoded correctly after an abort.

// File: rtl/sfr_pkg.sv
package sfr_pkg;
  typedef enum logic [2:0] {
    PH_CMD, PH_ADDR, PH_DUMMY, PH_DATA, PH_IGNORE
  } phase_e;

  localparam logic [7:0] OP_READ_X1 = 8'h0B;
  localparam logic [7:0] OP_READ_X2 = 8'h3B;
  localparam int CMD_BITS   = 8;
  localparam int ADDR_BITS  = 24;
  localparam int DUMMY_BITS = 8;
endpackage

// File: rtl/sfr_sync.sv
module sfr_sync #(
  parameter int          W       = 3,
  parameter int          STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] st_q [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) st_q[0] <= RST_VAL;
        else         st_q[0] <= d_i;
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) st_q[g] <= RST_VAL;
        else         st_q[g] <= st_q[g-1];
    end
  end

  assign q_o = st_q[STAGES-1];
endmodule

// File: rtl/sfr_cmd_decode.sv
module sfr_cmd_decode
  import sfr_pkg::*;
#(
  parameter int AW = 19
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          sel_i,
  input  logic          rise_i,
  input  logic          sd_i,
  output logic          dual_o,
  output logic          load_o,
  output logic [AW-1:0] load_addr_o,
  output logic          start_o
);
  localparam int SHW = (AW - 1 > CMD_BITS - 1) ? AW - 1 : CMD_BITS - 1;
  localparam int CW  = $clog2(ADDR_BITS);

  phase_e          phase_q;
  logic [CW-1:0]   cnt_q;
  logic [SHW-1:0]  sh_q;
  logic [7:0]      op_w;

  assign op_w = {sh_q[CMD_BITS-2:0], sd_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q     <= PH_CMD;
      cnt_q       <= '0;
      sh_q        <= '0;
      dual_o      <= 1'b0;
      load_o      <= 1'b0;
      load_addr_o <= '0;
      start_o     <= 1'b0;
    end else begin
      load_o  <= 1'b0;
      start_o <= 1'b0;
      if (!sel_i) begin
        phase_q <= PH_CMD;
        cnt_q   <= '0;
      end else if (rise_i) begin
        sh_q <= {sh_q[SHW-2:0], sd_i};
        case (phase_q)
          PH_CMD: begin
            if (cnt_q == CW'(CMD_BITS - 1)) begin
              cnt_q <= '0;
              if (op_w == OP_READ_X1) begin
                dual_o <= 1'b0; phase_q <= PH_ADDR;
              end else if (op_w == OP_READ_X2) begin
                dual_o <= 1'b1; phase_q <= PH_ADDR;
              end else begin
                phase_q <= PH_IGNORE;
              end
            end else cnt_q <= cnt_q + 1'b1;
          end
          PH_ADDR: begin
            if (cnt_q == CW'(ADDR_BITS - 1)) begin
              cnt_q       <= '0;
              load_o      <= 1'b1;
              load_addr_o <= {sh_q[AW-2:0], sd_i};  // high address bits shift out unused
              phase_q     <= PH_DUMMY;
            end else cnt_q <= cnt_q + 1'b1;
          end
          PH_DUMMY: begin
            if (cnt_q == CW'(DUMMY_BITS - 1)) begin
              cnt_q   <= '0;
              start_o <= 1'b1;
              phase_q <= PH_DATA;
            end else cnt_q <= cnt_q + 1'b1;
          end
          default: ;
        endcase
      end
    end
  end

  AST_START_FROM_DUMMY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |-> $past(phase_q) == PH_DUMMY);  // R2
  AST_IGNORE_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i && phase_q == PH_IGNORE) |=> phase_q == PH_IGNORE);  // R1
endmodule

// File: rtl/sfr_stream.sv
module sfr_stream #(
  parameter int AW = 19
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          sel_i,
  input  logic          fall_i,
  input  logic          dual_i,
  input  logic          load_i,
  input  logic [AW-1:0] load_addr_i,
  input  logic          start_i,
  output logic          mem_en_o,
  output logic [AW-1:0] mem_addr_o,
  input  logic [7:0]    mem_rdata_i,
  output logic          dq1_o,
  output logic          dq1_oe_o,
  output logic          dq0_o,
  output logic          dq0_oe_o
);
  logic          busy_q, vld_q;
  logic [2:0]    slot_q;
  logic [7:0]    cur_q, pre_q;
  logic [AW-1:0] nxt_q;
  logic          last_w;

  assign last_w = dual_i ? (slot_q == 3'd3) : (slot_q == 3'd7);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q     <= 1'b0;
      vld_q      <= 1'b0;
      slot_q     <= '0;
      cur_q      <= '0;
      pre_q      <= '0;
      nxt_q      <= '0;
      mem_en_o   <= 1'b0;
      mem_addr_o <= '0;
      dq1_o      <= 1'b0;
      dq1_oe_o   <= 1'b0;
      dq0_o      <= 1'b0;
      dq0_oe_o   <= 1'b0;
    end else begin
      mem_en_o <= 1'b0;
      vld_q    <= mem_en_o;
      if (vld_q) pre_q <= mem_rdata_i;
      if (!sel_i) begin
        busy_q   <= 1'b0;
        slot_q   <= '0;
        dq1_oe_o <= 1'b0;
        dq0_oe_o <= 1'b0;
      end else if (load_i) begin
        mem_en_o   <= 1'b1;
        mem_addr_o <= load_addr_i;
        nxt_q      <= load_addr_i + AW'(1);
      end else if (start_i) begin
        cur_q      <= pre_q;
        busy_q     <= 1'b1;
        slot_q     <= '0;
        mem_en_o   <= 1'b1;
        mem_addr_o <= nxt_q;
        nxt_q      <= nxt_q + AW'(1);
      end else if (fall_i && busy_q) begin
        dq1_oe_o <= 1'b1;
        dq0_oe_o <= dual_i;
        dq1_o    <= cur_q[7];
        if (dual_i) begin
          dq0_o <= cur_q[6];
          cur_q <= {cur_q[5:0], 2'b00};
        end else begin
          cur_q <= {cur_q[6:0], 1'b0};
        end
        if (last_w) begin
          // prefetched byte replaces the one just finished
          cur_q      <= pre_q;
          slot_q     <= '0;
          mem_en_o   <= 1'b1;
          mem_addr_o <= nxt_q;
          nxt_q      <= nxt_q + AW'(1);
        end else begin
          slot_q <= slot_q + 1'b1;
        end
      end
    end
  end

  AST_HIZ_WHEN_DESELECTED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sel_i |=> (!dq1_oe_o && !dq0_oe_o));  // R7
  AST_DQ0_DUAL_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dq0_oe_o |-> dual_i);  // R5
  AST_DQ1_ON_FALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(fall_i && busy_q) |=> $stable(dq1_o));  // R3
  AST_NO_BACK_TO_BACK_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_en_o |=> !mem_en_o);  // R8
  AST_OE_ONLY_IN_DATA: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(dq1_oe_o) |-> $past(busy_q));  // R9
endmodule

// File: rtl/sfr_target.sv
module sfr_target #(
  parameter int MEM_BYTES   = 524288,
  parameter int SYNC_STAGES = 2,
  localparam int AW         = $clog2(MEM_BYTES)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          sel_ni,
  input  logic          ser_clk_i,
  input  logic          dq0_i,
  output logic          dq0_o,
  output logic          dq0_oe_o,
  output logic          dq1_o,
  output logic          dq1_oe_o,
  output logic          mem_en_o,
  output logic [AW-1:0] mem_addr_o,
  input  logic [7:0]    mem_rdata_i
);
  logic [2:0]    pins_s;
  logic          sel_n_s, sck_s, sd_s, sck_d;
  logic          sel_w, rise_w, fall_w;
  logic          dual_w, load_w, start_w;
  logic [AW-1:0] load_addr_w;

  sfr_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({sel_ni, ser_clk_i, dq0_i}),
    .q_o   (pins_s)
  );

  assign {sel_n_s, sck_s, sd_s} = pins_s;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) sck_d <= 1'b0;
    else         sck_d <= sck_s;

  assign sel_w  = ~sel_n_s;
  assign rise_w = sck_s & ~sck_d;
  assign fall_w = ~sck_s & sck_d;

  sfr_cmd_decode #(.AW(AW)) u_dec (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sel_i      (sel_w),
    .rise_i     (rise_w),
    .sd_i       (sd_s),
    .dual_o     (dual_w),
    .load_o     (load_w),
    .load_addr_o(load_addr_w),
    .start_o    (start_w)
  );

  sfr_stream #(.AW(AW)) u_str (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sel_i      (sel_w),
    .fall_i     (fall_w),
    .dual_i     (dual_w),
    .load_i     (load_w),
    .load_addr_i(load_addr_w),
    .start_i    (start_w),
    .mem_en_o   (mem_en_o),
    .mem_addr_o (mem_addr_o),
    .mem_rdata_i(mem_rdata_i),
    .dq1_o      (dq1_o),
    .dq1_oe_o   (dq1_oe_o),
    .dq0_o      (dq0_o),
    .dq0_oe_o   (dq0_oe_o)
  );
endmodule

// File: tb/sim_sfr_target.sv
`timescale 1ns/1ps
module sim_sfr_target;
  localparam int MEM_BYTES = 524288;
  localparam int AW = $clog2(MEM_BYTES);

  logic clk = 1'b0, rst_n = 1'b0;
  logic sel_n = 1'b1, sck = 1'b0, sd = 1'b0;
  logic dq0, dq0_oe, dq1, dq1_oe, mem_en;
  logic [AW-1:0] mem_addr;
  logic [7:0] mem_rdata = '0;
  int n_chk = 0, n_err = 0, req_cnt = 0;
  logic [7:0] exp_q[$];

  always #4 clk = ~clk;

  sfr_target #(.MEM_BYTES(MEM_BYTES)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .sel_ni(sel_n), .ser_clk_i(sck), .dq0_i(sd),
    .dq0_o(dq0), .dq0_oe_o(dq0_oe), .dq1_o(dq1), .dq1_oe_o(dq1_oe),
    .mem_en_o(mem_en), .mem_addr_o(mem_addr), .mem_rdata_i(mem_rdata)
  );

  function automatic logic [7:0] pat(logic [AW-1:0] a);
    return a[7:0] ^ {a[14:8], a[15]} ^ (8'(a[18:16]) * 8'd29) ^ 8'h5A;
  endfunction

  // behavioural memory: one clock read latency
  always @(posedge clk) if (mem_en) mem_rdata <= pat(mem_addr);
  always @(negedge clk) if (mem_en) req_cnt++;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic hdr_clock(input logic b);
    sck = 1'b0; sd = b;
    repeat (4) @(negedge clk);
    sck = 1'b1;
    repeat (4) @(negedge clk);
    check(!dq1_oe && !dq0_oe, "R9", "oe during header", {dq1_oe, dq0_oe}, 0);
  endtask

  task automatic send_hdr(input logic [7:0] op, input logic [23:0] addr);
    @(negedge clk); sel_n = 1'b0;
    repeat (4) @(negedge clk);
    for (int i = 7; i >= 0; i--) hdr_clock(op[i]);
    for (int i = 23; i >= 0; i--) hdr_clock(addr[i]);
    for (int i = 0; i < 8; i++) hdr_clock(1'b0);
  endtask

  // model: queue the bytes expected from the start address, then compare slice by slice
  task automatic read_bytes(input bit dual, input logic [23:0] addr, input int n, input string req);
    logic [7:0] got;
    logic [AW-1:0] a;
    exp_q.delete();
    a = addr[AW-1:0];
    for (int b = 0; b < n; b++) begin
      exp_q.push_back(pat(a));
      a = a + AW'(1);
    end
    for (int b = 0; b < n; b++) begin
      got = '0;
      for (int s = 0; s < (dual ? 4 : 8); s++) begin
        sck = 1'b0;
        repeat (4) @(negedge clk);
        sck = 1'b1;
        repeat (3) @(negedge clk);
        if (dual) got = {got[5:0], dq1, dq0};
        else      got = {got[6:0], dq1};
        check(dq1_oe && (dq0_oe == dual), dual ? "R5" : "R4", "oe in data",
              {dq1_oe, dq0_oe}, {1'b1, dual});
        @(negedge clk);
      end
      check(got == exp_q[b], req, "byte", got, exp_q[b]);
    end
  endtask

  task automatic deselect;
    @(negedge clk); sel_n = 1'b1; sck = 1'b0;
    repeat (4) @(negedge clk);
    check(!dq1_oe && !dq0_oe, "R7", "oe after deselect", {dq1_oe, dq0_oe}, 0);
    repeat (4) @(negedge clk);
  endtask

  task automatic summary;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual=%0h expected=%0h", 1, 0);
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(!dq1_oe && !dq0_oe && !mem_en, "R7", "reset state", {dq1_oe, dq0_oe, mem_en}, 0);

    // R1 R2 R3 R4 R8: one-line read, request count N+2
    req_cnt = 0;
    send_hdr(8'h0B, 24'h000100);
    read_bytes(1'b0, 24'h000100, 4, "R4");
    deselect();
    check(req_cnt == 6, "R8", "request count", req_cnt, 6);

    // R5: two-line read
    req_cnt = 0;
    send_hdr(8'h3B, 24'h012345);
    read_bytes(1'b1, 24'h012345, 5, "R5");
    deselect();
    check(req_cnt == 7, "R8", "request count dual", req_cnt, 7);

    // R6: high address bits dropped, wrap past top
    send_hdr(8'h0B, 24'hFFFFFE);
    read_bytes(1'b0, 24'hFFFFFE, 4, "R6");
    deselect();
    send_hdr(8'h3B, 24'h07FFFD);
    read_bytes(1'b1, 24'h07FFFD, 5, "R6");
    deselect();

    // R1: unknown opcode ignored, even with further clocks
    send_hdr(8'h03, 24'h000010);
    for (int i = 0; i < 24; i++) hdr_clock(1'b1);
    check(!dq1_oe && !dq0_oe, "R1", "ignored opcode", {dq1_oe, dq0_oe}, 0);
    deselect();

    // R7: fresh command after an ignored one
    send_hdr(8'h3B, 24'h0ABCDE);
    read_bytes(1'b1, 24'h0ABCDE, 2, "R7");
    deselect();

    // R7: abort in mid-byte, then a new read decodes cleanly
    send_hdr(8'h0B, 24'h000040);
    read_bytes(1'b0, 24'h000040, 1, "R3");
    for (int i = 0; i < 3; i++) begin
      sck = 1'b0; repeat (4) @(negedge clk);
      sck = 1'b1; repeat (4) @(negedge clk);
    end
    deselect();
    send_hdr(8'h0B, 24'h055AA0);
    read_bytes(1'b0, 24'h055AA0, 3, "R7");
    deselect();

    summary();
    $finish;
  end
endmodule